// File: doc/BRIEF.md
# Receive Interrupt Coalescing Controller

This block produces the single interrupt line of a CAN controller. It watches the occupancy counts of the receive and transmit queues, the overrun event and the bus-state fields reported by the protocol engine. It turns them into a small set of sticky flags. Each flag is gated by its own enable bit, and the enabled flags are merged into one level-sensitive interrupt.

The point of the block is to coalesce receive interrupts. A receive interrupt is raised either when the number of queued frames rises above a programmed level, or when a non-empty receive queue has been left alone for a programmed number of microseconds. Software can then choose between low latency and few interrupts.

A prescaler derives a microsecond tick from the core clock. Four 32-bit registers are reached through a simple write port and a combinational read port: enable, level, timeout and status. Queue storage and the bus protocol engine sit outside the block.

Top module: `rxirq_coalesce`

## Requirements
- R1: After reset the interrupt output is 0, the enable register (address 0) reads 0, the level register (address 1) reads 0 and the timeout register (address 2) reads the parameter TOUT_RST (default 1000).
- R2: Status bit 16 (receive level flag) sets when the receive count is strictly greater than the receive level in level-register bits 15:0. With a level of 0 it sets on one frame. With a level of 254 it sets on 255 frames but not on 254.
- R3: Status bit 24 (transmit flag) sets when the transmit count is at or below the transmit level in level-register bits 31:16.
- R4: A one-cycle pulse on ovr_event_i sets status bit 17 (overrun flag).
- R5: Status bits 19:18 follow the transmit bus state and bits 21:20 follow the receive bus state (0 error-active, 1 warning, 2 passive, 3 bus-off). Any change in either field sets status bit 22 (state-change flag).
- R6: Status bit 23 (timeout flag) sets when the receive queue is non-empty and has seen no rx_access_i for the number of microsecond ticks held in timeout-register bits 15:0. One tick occurs every TICK_DIV clocks. The idle timer restarts on rx_access_i and holds at zero while the queue is empty.
- R7: Writing 1 to a flag bit (16, 17, 22, 23, 24) of the status register (address 3) clears it. Writing 0 leaves it unchanged. The state fields are unaffected by writes. A set condition in the same cycle as the clear wins, and the flag stays set.
- R8: irq_o is 1 exactly when an enabled flag is set: receive level with enable bit 0, overrun with bit 1, state change with bit 6, transmit with bit 16.
- R9: The timeout flag raises irq_o only when both enable bit 7 and enable bit 0 are set.
- R10: Enable bit 17 (error group) lets the overrun and state-change flags raise irq_o even when their own enable bits are clear.
- R11: Registers read back what was written, restricted to their defined bits. Status bits 7:0 give the receive count and bits 15:8 give the transmit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 32 | Register read data (combinational) |
| rx_count_i | input | CNT_W | Frames held in the receive queue |
| tx_count_i | input | CNT_W | Frames held in the transmit queue |
| rx_access_i | input | 1 | Receive window read or receive acknowledge |
| ovr_event_i | input | 1 | Receive overrun pulse |
| tx_state_i | input | 2 | Transmit bus state |
| rx_state_i | input | 2 | Receive bus state |
| irq_o | output | 1 | Level-sensitive interrupt |

## Verification
Two functions can land in the same cycle: a software clear of a flag and the hardware event that sets it. The bench provokes this by writing 1 to the overrun bit in the very cycle that ovr_event_i pulses. It also pulses rx_access_i together with a clear of the timeout flag. In the first case the flag must still read 1 afterwards. In the second case the flag must read 0 and must not return until a full new timeout window has elapsed. The timeout window is judged with a guard band of one tick on each side, because the phase of the prescaler is not known to the software.

// File: rtl/rxirq_pkg.sv
// Shared definitions for the receive interrupt coalescing controller:
// register selects, flag and enable bit positions, bus-state codes and
// the packed flag vector carried between the submodules.
package rxirq_pkg;

    typedef enum logic [1:0] {
        REG_IEN  = 2'd0,
        REG_LVL  = 2'd1,
        REG_TOUT = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        BUS_ACTIVE  = 2'd0,
        BUS_WARN    = 2'd1,
        BUS_PASSIVE = 2'd2,
        BUS_OFF     = 2'd3
    } bus_state_e;

    // Status register bit positions (software decodes these)
    localparam int FB_RXL   = 16;
    localparam int FB_OVR   = 17;
    localparam int FB_TST   = 18;
    localparam int FB_RST   = 20;
    localparam int FB_CHG   = 22;
    localparam int FB_TOUT  = 23;
    localparam int FB_TX    = 24;

    // Enable register bit positions
    localparam int EN_RX    = 0;
    localparam int EN_OVR   = 1;
    localparam int EN_CHG   = 6;
    localparam int EN_TOUT  = 7;
    localparam int EN_TX    = 16;
    localparam int EN_ERR   = 17;

    localparam logic [31:0] EN_MASK = (32'd1 << EN_RX) | (32'd1 << EN_OVR) |
                                      (32'd1 << EN_CHG) | (32'd1 << EN_TOUT) |
                                      (32'd1 << EN_TX) | (32'd1 << EN_ERR);

    // Sticky flags; bit 0 is the receive level flag
    typedef struct packed {
        logic tx;
        logic tout;
        logic chg;
        logic ovr;
        logic rxl;
    } flag_vec_t;

endpackage

// File: rtl/rxirq_tick_gen.sv
// Microsecond tick prescaler.
// Emits a one-cycle pulse every DIV clocks. DIV is chosen so that DIV
// core clocks last one microsecond. Assumes DIV >= 1; DIV of 1 gives a
// tick on every cycle.
module rxirq_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    generate
        if (DIV <= 1) begin : g_every_cycle
            assign tick_o = 1'b1;
        end else begin : g_divider
            localparam int W = $clog2(DIV);
            localparam logic [W-1:0] LAST = W'(DIV - 1);
            logic [W-1:0] div_q;

            // Free-running modulo-DIV counter
            always_ff @(posedge clk) begin
                if (!rst_n)            div_q <= '0;
                else if (div_q == LAST) div_q <= '0;
                else                   div_q <= div_q + 1'b1;
            end

            assign tick_o = (div_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/rxirq_idle_timer.sv
// Receive idle timer.
// Counts microsecond ticks while the receive queue is non-empty and
// untouched. It clears on any access and holds at zero while the queue is
// empty. The count saturates at its maximum. Expiry is reported while
// the count has reached the programmed limit and no access is present in
// the same cycle.
module rxirq_idle_timer #(
    parameter int TOUT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              nonempty_i,
    input  logic              access_i,
    input  logic [TOUT_W-1:0] limit_i,
    output logic              expired_o
);

    localparam logic [TOUT_W-1:0] CNT_MAX = '1;

    logic [TOUT_W-1:0] idle_q;

    // Idle tick counter with restart on access and hold on empty
    always_ff @(posedge clk) begin
        if (!rst_n)                       idle_q <= '0;
        else if (!nonempty_i || access_i) idle_q <= '0;
        else if (tick_i && idle_q != CNT_MAX) idle_q <= idle_q + 1'b1;
    end

    assign expired_o = nonempty_i && !access_i && (idle_q >= limit_i);

endmodule

// File: rtl/rxirq_flag_bank.sv
// Sticky flag storage with write-one-to-clear.
// It also captures the two bus-state fields and raises the state-change
// flag whenever either incoming field differs from the captured copy.
// A set condition wins over a clear arriving in the same cycle. The
// captured states reset to error-active.
module rxirq_flag_bank
    import rxirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t set_i,
    input  flag_vec_t clr_i,
    input  logic [1:0] tx_state_i,
    input  logic [1:0] rx_state_i,
    output flag_vec_t flags_o,
    output logic [1:0] tx_state_o,
    output logic [1:0] rx_state_o
);

    flag_vec_t  flag_q;
    flag_vec_t  set_all;
    logic [1:0] txs_q;
    logic [1:0] rxs_q;
    logic       state_moved;

    // Detect any movement in either bus-state field
    always_comb begin
        state_moved = (tx_state_i != txs_q) || (rx_state_i != rxs_q);
        set_all     = set_i;
        set_all.chg = set_i.chg | state_moved;
    end

    // Capture bus states
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txs_q <= BUS_ACTIVE;
            rxs_q <= BUS_ACTIVE;
        end else begin
            txs_q <= tx_state_i;
            rxs_q <= rx_state_i;
        end
    end

    // Sticky flags, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_i) | set_all;
    end

    assign flags_o    = flag_q;
    assign tx_state_o = txs_q;
    assign rx_state_o = rxs_q;

endmodule

// File: rtl/rxirq_irq_merge.sv
// Interrupt merge.
// Combines the registered flags with the enable register into one level
// output. The timeout flag additionally needs the receive enable. The
// error-group enable opens both error flags.
module rxirq_irq_merge
    import rxirq_pkg::*;
(
    input  flag_vec_t   flags_i,
    input  logic [31:0] ien_i,
    output logic        irq_o
);

    logic err_open;
    logic unused_en_bits;

    assign unused_en_bits = ^{ien_i[31:18], ien_i[15:8], ien_i[5:2]};

    // Weigh each flag against its enable
    always_comb begin
        err_open = ien_i[EN_ERR];
        irq_o = (flags_i.rxl  && ien_i[EN_RX])
              | (flags_i.ovr  && (ien_i[EN_OVR] || err_open))
              | (flags_i.chg  && (ien_i[EN_CHG] || err_open))
              | (flags_i.tout && ien_i[EN_TOUT] && ien_i[EN_RX])
              | (flags_i.tx   && ien_i[EN_TX]);
    end

endmodule

// File: rtl/rxirq_coalesce.sv
// Receive interrupt coalescing controller, top level.
// Holds the enable, level and timeout registers. It computes the flag
// set conditions from the queue counts and event inputs, and drives the
// single interrupt line. Assumes CNT_W <= 8, LVL_W >= CNT_W,
// 2*LVL_W <= 32 and TOUT_W <= 32.
module rxirq_coalesce
    import rxirq_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int LVL_W    = 16,
    parameter int TOUT_W   = 16,
    parameter int TICK_DIV = 4,
    parameter int TOUT_RST = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [31:0]      wr_data_i,
    input  logic [1:0]       rd_addr_i,
    output logic [31:0]      rd_data_o,
    input  logic [CNT_W-1:0] rx_count_i,
    input  logic [CNT_W-1:0] tx_count_i,
    input  logic             rx_access_i,
    input  logic             ovr_event_i,
    input  logic [1:0]       tx_state_i,
    input  logic [1:0]       rx_state_i,
    output logic             irq_o
);

    localparam int LVL_TOT = 2 * LVL_W;

    logic [31:0]       ien_q;
    logic [LVL_TOT-1:0] lvl_q;
    logic [TOUT_W-1:0] tout_q;
    logic [LVL_W-1:0]  rx_cnt_ext;
    logic [LVL_W-1:0]  tx_cnt_ext;
    logic              tick;
    logic              expired;
    logic              stat_wr;
    flag_vec_t         flag_set;
    flag_vec_t         flag_clr;
    flag_vec_t         flag_q;
    logic [1:0]        txs_q;
    logic [1:0]        rxs_q;

    // Configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= '0;
            lvl_q  <= '0;
            tout_q <= TOUT_W'(TOUT_RST);
        end else if (wr_en_i) begin
            case (reg_sel_e'(wr_addr_i))
                REG_IEN:  ien_q  <= wr_data_i & EN_MASK;
                REG_LVL:  lvl_q  <= wr_data_i[LVL_TOT-1:0];
                REG_TOUT: tout_q <= wr_data_i[TOUT_W-1:0];
                default:  ;
            endcase
        end
    end

    assign rx_cnt_ext = LVL_W'(rx_count_i);
    assign tx_cnt_ext = LVL_W'(tx_count_i);
    assign stat_wr    = wr_en_i && (reg_sel_e'(wr_addr_i) == REG_STAT);

    // Flag set conditions from counts and events
    always_comb begin
        flag_set.rxl  = rx_cnt_ext > lvl_q[LVL_W-1:0];
        flag_set.tx   = tx_cnt_ext <= lvl_q[LVL_TOT-1:LVL_W];
        flag_set.ovr  = ovr_event_i;
        flag_set.tout = expired;
        flag_set.chg  = 1'b0;
    end

    // Software clears, one per flag bit position
    always_comb begin
        flag_clr.rxl  = stat_wr && wr_data_i[FB_RXL];
        flag_clr.ovr  = stat_wr && wr_data_i[FB_OVR];
        flag_clr.chg  = stat_wr && wr_data_i[FB_CHG];
        flag_clr.tout = stat_wr && wr_data_i[FB_TOUT];
        flag_clr.tx   = stat_wr && wr_data_i[FB_TX];
    end

    rxirq_tick_gen #(.DIV(TICK_DIV)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    rxirq_idle_timer #(.TOUT_W(TOUT_W)) idle_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .nonempty_i (rx_count_i != '0),
        .access_i   (rx_access_i),
        .limit_i    (tout_q),
        .expired_o  (expired)
    );

    rxirq_flag_bank flags_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (flag_set),
        .clr_i      (flag_clr),
        .tx_state_i (tx_state_i),
        .rx_state_i (rx_state_i),
        .flags_o    (flag_q),
        .tx_state_o (txs_q),
        .rx_state_o (rxs_q)
    );

    rxirq_irq_merge merge_i (
        .flags_i (flag_q),
        .ien_i   (ien_q),
        .irq_o   (irq_o)
    );

    // Register read multiplexer
    always_comb begin
        rd_data_o = '0;
        case (reg_sel_e'(rd_addr_i))
            REG_IEN:  rd_data_o = ien_q;
            REG_LVL:  rd_data_o = 32'(lvl_q);
            REG_TOUT: rd_data_o = 32'(tout_q);
            REG_STAT: begin
                rd_data_o[7:0]          = 8'(rx_count_i);
                rd_data_o[15:8]         = 8'(tx_count_i);
                rd_data_o[FB_RXL]       = flag_q.rxl;
                rd_data_o[FB_OVR]       = flag_q.ovr;
                rd_data_o[FB_TST +: 2]  = txs_q;
                rd_data_o[FB_RST +: 2]  = rxs_q;
                rd_data_o[FB_CHG]       = flag_q.chg;
                rd_data_o[FB_TOUT]      = flag_q.tout;
                rd_data_o[FB_TX]        = flag_q.tx;
            end
            default: rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/rxirq_coalesce_chk.sv
// Assertion checker for the coalescing controller, attached by bind.
// The flags vector is ordered {tx, tout, chg, ovr, rxl}.
module rxirq_coalesce_chk #(
    parameter int CNT_W = 8,
    parameter int LVL_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic [31:0]      ien,
    input logic [4:0]       flags,
    input logic             ovr_event,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [31:0]      wr_data,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] tx_count,
    input logic [2*LVL_W-1:0] lvl
);

    // R4
    ovr_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_event |=> flags[1]);

    // R7
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3 && wr_data[17] && !ovr_event) |=> !flags[1]);

    // R2
    rx_level_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (LVL_W'(rx_count) > lvl[LVL_W-1:0]) |=> flags[0]);

    // R3
    tx_level_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (LVL_W'(tx_count) <= lvl[2*LVL_W-1:LVL_W]) |=> flags[4]);

    // R8
    quiet_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 32'd0) |-> !irq);

    // R9
    tout_needs_rx_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 32'h0000_0080) |-> !irq);

endmodule

bind rxirq_coalesce rxirq_coalesce_chk #(.CNT_W(CNT_W), .LVL_W(LVL_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq_o),
    .ien       (ien_q),
    .flags     (flag_q),
    .ovr_event (ovr_event_i),
    .wr_en     (wr_en_i),
    .wr_addr   (wr_addr_i),
    .wr_data   (wr_data_i),
    .rx_count  (rx_count_i),
    .tx_count  (tx_count_i),
    .lvl       (lvl_q)
);

// File: tb/rxirq_coalesce_tb.sv
// Directed bench for the receive interrupt coalescing controller.
module rxirq_coalesce_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam logic [31:0] ALL_FLAGS = 32'h01C3_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  rx_count = '0;
    logic [7:0]  tx_count = '0;
    logic        rx_access = 1'b0;
    logic        ovr_event = 1'b0;
    logic [1:0]  tx_state = '0;
    logic [1:0]  rx_state = '0;
    logic        irq;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxirq_coalesce #(.TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .rx_count_i(rx_count), .tx_count_i(tx_count), .rx_access_i(rx_access),
        .ovr_event_i(ovr_event), .tx_state_i(tx_state), .rx_state_i(rx_state),
        .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse_ovr();
        @(negedge clk); ovr_event = 1'b1;
        @(negedge clk); ovr_event = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq after reset", 32'(irq), 32'd0);
        rd(2'd0, v); check("R1 enable reset", v, 32'd0);
        rd(2'd1, v); check("R1 level reset", v, 32'd0);
        rd(2'd2, v); check("R1 timeout reset", v, 32'd1000);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(2'd1, 32'h0005_00FE); rd(2'd1, v); check("R11 level readback", v, 32'h0005_00FE);
        wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); check("R11 enable defined bits", v, 32'h0003_00C3);
        wr(2'd0, 32'd0);
        wr(2'd2, 32'hABCD_1234); rd(2'd2, v); check("R11 timeout 16 bits", v, 32'h0000_1234);
        wr(2'd2, 32'd1000);
        rx_count = 8'd5; tx_count = 8'd7; #1;
        rd(2'd3, v); check("R11 status counts", v & 32'hFFFF, 32'h0705);
        rx_count = 8'd0; tx_count = 8'd0;
    endtask

    task automatic t_rx_level();
        logic [31:0] v;
        wr(2'd1, 32'd0); wr(2'd3, ALL_FLAGS);
        rd(2'd3, v); check("R2 no frames level 0", 32'(v[16]), 32'd0);
        @(negedge clk); rx_count = 8'd1; cycles(2);
        rd(2'd3, v); check("R2 one frame level 0", 32'(v[16]), 32'd1);
        wr(2'd1, 32'd254); rx_count = 8'd254; cycles(1);
        wr(2'd3, 32'h0001_0000); cycles(1);
        rd(2'd3, v); check("R2 254 frames level 254", 32'(v[16]), 32'd0);
        rx_count = 8'd255; cycles(2);
        rd(2'd3, v); check("R2 255 frames level 254", 32'(v[16]), 32'd1);
        rx_count = 8'd0; cycles(2);
    endtask

    task automatic t_tx();
        logic [31:0] v;
        wr(2'd1, 32'h0005_00FE); tx_count = 8'd6; cycles(1);
        wr(2'd3, 32'h0100_0000); cycles(1);
        rd(2'd3, v); check("R3 tx above level", 32'(v[24]), 32'd0);
        tx_count = 8'd5; cycles(2);
        rd(2'd3, v); check("R3 tx at level", 32'(v[24]), 32'd1);
        tx_count = 8'd100; cycles(1); wr(2'd3, 32'h0100_0000);
    endtask

    task automatic t_ovr();
        logic [31:0] v;
        wr(2'd3, 32'h0002_0000);
        rd(2'd3, v); check("R7 overrun cleared", 32'(v[17]), 32'd0);
        pulse_ovr();
        rd(2'd3, v); check("R4 overrun pulse", 32'(v[17]), 32'd1);
        wr(2'd3, 32'd0);
        rd(2'd3, v); check("R7 write zero keeps", 32'(v[17]), 32'd1);
        wr(2'd3, 32'h0002_0000);
        rd(2'd3, v); check("R7 write one clears", 32'(v[17]), 32'd0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 32'h0002_0000; ovr_event = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; ovr_event = 1'b0;
        rd(2'd3, v); check("R7 set wins over clear", 32'(v[17]), 32'd1);
        wr(2'd3, 32'h0002_0000);
    endtask

    task automatic t_state();
        logic [31:0] v;
        wr(2'd3, ALL_FLAGS);
        @(negedge clk); tx_state = 2'd2; cycles(2);
        rd(2'd3, v); check("R5 tx state field", 32'(v[19:18]), 32'd2);
        check("R5 change flag on tx", 32'(v[22]), 32'd1);
        wr(2'd3, 32'h00FC_0000);
        rd(2'd3, v); check("R7 state field kept", 32'(v[19:18]), 32'd2);
        check("R7 change flag cleared", 32'(v[22]), 32'd0);
        @(negedge clk); rx_state = 2'd3; cycles(2);
        rd(2'd3, v); check("R5 rx state field", 32'(v[21:20]), 32'd3);
        check("R5 change flag on rx", 32'(v[22]), 32'd1);
        wr(2'd3, 32'h0040_0000);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        wr(2'd1, 32'h0005_00FE); wr(2'd2, 32'd3);
        rx_count = 8'd0; cycles(10); wr(2'd3, 32'h0080_0000);
        rx_count = 8'd1; cycles(8);
        rd(2'd3, v); check("R6 before window", 32'(v[23]), 32'd0);
        cycles(8);
        rd(2'd3, v); check("R6 after window", 32'(v[23]), 32'd1);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 32'h0080_0000; rx_access = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; rx_access = 1'b0;
        cycles(7);
        rd(2'd3, v); check("R6 access restarts timer", 32'(v[23]), 32'd0);
        cycles(8);
        rd(2'd3, v); check("R6 expires after restart", 32'(v[23]), 32'd1);
        rx_count = 8'd0; cycles(40); wr(2'd3, 32'h0080_0000);
        rx_count = 8'd1; cycles(8);
        rd(2'd3, v); check("R6 timer held while empty", 32'(v[23]), 32'd0);
        rx_count = 8'd0; cycles(2); wr(2'd3, 32'h0080_0000);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        rx_count = 8'd0; tx_count = 8'd100;
        wr(2'd1, 32'h0005_00FE); wr(2'd0, 32'h0003_00C3); cycles(2);
        wr(2'd3, ALL_FLAGS);
        check("R8 no flags no irq", 32'(irq), 32'd0);
        wr(2'd0, 32'h0000_0002); pulse_ovr();
        check("R8 overrun enabled", 32'(irq), 32'd1);
        wr(2'd3, 32'h0002_0000);
        check("R8 overrun cleared", 32'(irq), 32'd0);
        wr(2'd0, 32'h0001_0000); tx_count = 8'd3; cycles(2);
        check("R8 tx enabled", 32'(irq), 32'd1);
        wr(2'd0, 32'd0);
        check("R8 tx disabled", 32'(irq), 32'd0);
        tx_count = 8'd100; cycles(1); wr(2'd3, 32'h0100_0000);
        wr(2'd2, 32'd0); wr(2'd0, 32'h0000_0080);
        rx_count = 8'd1; cycles(2);
        rd(2'd3, v); check("R6 zero timeout sets", 32'(v[23]), 32'd1);
        check("R9 timeout without rx enable", 32'(irq), 32'd0);
        wr(2'd0, 32'h0000_0081);
        check("R9 timeout with rx enable", 32'(irq), 32'd1);
        wr(2'd0, 32'd0); rx_count = 8'd0; cycles(1); wr(2'd3, ALL_FLAGS);
        wr(2'd0, 32'h0002_0000);
        check("R10 group enable idle", 32'(irq), 32'd0);
        pulse_ovr();
        check("R10 group enable overrun", 32'(irq), 32'd1);
        wr(2'd3, 32'h0002_0000);
        @(negedge clk); tx_state = 2'd1; cycles(1);
        check("R10 group enable state change", 32'(irq), 32'd1);
        wr(2'd3, 32'h0040_0000);
        check("R10 cleared", 32'(irq), 32'd0);
        wr(2'd0, 32'd0); wr(2'd2, 32'd1000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        cycles(4);
        rst_n = 1'b1;
        cycles(1);
        t_reset();
        t_regs();
        t_rx_level();
        t_tx();
        t_ovr();
        t_collide();
        t_state();
        t_timeout();
        t_irq();
        cycles(2);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule